// File: doc/BRIEF.md
# Level-Triggered DMA Request Sequencer

This block serves one DMA channel that is started by an active-low, level-sensitive request pin. Software arms the channel with one register write. That write carries an enable bit, a pin-mode bit that routes requests from the pin, and a transfer count. From the clock after that write, the sequencer watches the pin on every rising edge. A low level seen while the acceptance window is open is stored as a pending request. The sequencer then asks for the bus. When the grant arrives it starts a transfer. The transfer is a two-clock source read, whose data goes into a holding register, then a two-clock destination write of that data.

The pending request is dropped when the transfer starts, and the pin is not watched until the write has finished. After each write the count goes down by one. The bus is released for at least two clocks before the next request can be made, so a pin held low gives back-to-back transfers with a fixed gap. When the count reaches zero, the channel turns itself off, raises a one-clock done pulse and stops looking at the pin.

Top module: `lds_dma_seq`

## Requirements
- R1: A register write made while idle, with enable=1, pin-mode=1 and a nonzero count, sets `chan_on` in the next cycle. If pin-mode=0, enable=0 or the count is 0, `chan_on` stays 0 and a low pin never raises `bus_req`.
- R2: The pin is first sampled on the clock edge that follows the edge taking the arming write. `bus_req` is 0 in the cycle after the write edge and 1 one cycle later when the pin was already low.
- R3: A sampled low level is held as pending. `bus_req` stays 1 while waiting for the grant, even if the pin returns high.
- R4: Activation happens on the first edge where `bus_req` and `bus_gnt` are both 1. The pending request is cleared on that edge. Pin activity from activation until the write ends causes no further transfer.
- R5: A transfer is exactly 2 cycles of `rd_stb` followed at once by exactly 2 cycles of `wr_stb`. `bus_req` stays 1 throughout, and the two strobes are never high together.
- R6: During the write, `wr_data` equals the `rd_data` value present on the last read-cycle edge.
- R7: `remaining` goes down by one on the edge that ends each write cycle.
- R8: On the write that brings `remaining` to 0, `chan_on` falls and `done` is 1 for exactly one cycle. No further transfer follows, even with the pin held low.
- R9: Between transfers `bus_req` is low for at least 2 cycles. A pin held low gives the next transfer after a gap of exactly 2 cycles when the grant is already high.
- R10: After reset, `bus_req`, `rd_stb`, `wr_stb`, `done`, `chan_on` and `remaining` are all 0, and no request is pending.
- R11: A register write while a transfer is in progress (read, write or release gap) is ignored. It changes neither `remaining` nor `chan_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Register write strobe; the write ends on the edge that samples it |
| ctl_enable | input | 1 | Channel enable bit of the write |
| ctl_pin_mode | input | 1 | 1 routes requests from the pin |
| ctl_count | input | CNT_W | Number of transfers to run |
| req_n | input | 1 | Active-low level request pin (synchronous to clk) |
| bus_gnt | input | 1 | Bus grant |
| bus_req | output | 1 | Bus request |
| rd_stb | output | 1 | Source read cycle strobe |
| rd_data | input | DATA_W | Data returned by the source |
| wr_stb | output | 1 | Destination write cycle strobe |
| wr_data | output | DATA_W | Data written to the destination |
| remaining | output | CNT_W | Transfers left |
| chan_on | output | 1 | Channel enabled |
| done | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
Timing counts from the edge that samples a stimulus:
- **Arming write:** `chan_on` changes in the next cycle. A pin already low shows up as `bus_req` one cycle later, because sampling starts one edge after the write.
- **Grant:** the grant edge puts `rd_stb` high in the following cycle. `wr_stb` follows two cycles after that.
- **Write end:** `remaining`, `done` and `chan_on` change in the cycle after the final write edge.
- **Held pin:** a pin held low raises `bus_req` again in the third cycle after the write ends.

The bench drives inputs and samples outputs on falling edges. A behavioural model advances on rising edges, so every comparison lands in the cycle in which each register has already taken its new value.

// File: rtl/lds_pkg.sv
package lds_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_GAP   = 2'd3
  } lds_state_e;

  // True on the final clock of a phase that lasts len clocks.
  function automatic logic phase_last(input int unsigned ph, input int unsigned len);
    return (ph + 1) >= len;
  endfunction

endpackage

// File: rtl/lds_accept.sv
module lds_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic close_i,
  input  logic pin_n_i,
  output logic accept_o,
  output logic pending_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept_o  <= 1'b0;
      pending_o <= 1'b0;
    end else begin
      if (open_i)       accept_o <= 1'b1;
      else if (close_i) accept_o <= 1'b0;

      if (close_i)                    pending_o <= 1'b0;
      else if (accept_o && !pin_n_i)  pending_o <= 1'b1;
    end
  end

endmodule

// File: rtl/lds_count.sv
module lds_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);

  function automatic logic [CNT_W-1:0] minus_one(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  function automatic logic is_final(input logic [CNT_W-1:0] v);
    return v == CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      count_o <= '0;
    else if (load_i) count_o <= load_val_i;
    else if (dec_i)  count_o <= minus_one(count_o);
  end

  assign last_o = is_final(count_o);

endmodule

// File: rtl/lds_fsm.sv
module lds_fsm
  import lds_pkg::*;
#(
  parameter int RD_CYC  = 2,
  parameter int WR_CYC  = 2,
  parameter int GAP_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output lds_state_e state_o,
  output logic       idle_o,
  output logic       rd_stb_o,
  output logic       wr_stb_o,
  output logic       capture_o,
  output logic       wr_end_o
);

  localparam int MAXC = (RD_CYC > WR_CYC) ? ((RD_CYC > GAP_CYC) ? RD_CYC : GAP_CYC)
                                          : ((WR_CYC > GAP_CYC) ? WR_CYC : GAP_CYC);
  localparam int PH_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  lds_state_e      st_q;
  logic [PH_W-1:0] ph_q;
  logic            rd_last, wr_last, gap_last;

  assign rd_last  = phase_last(32'(ph_q), RD_CYC);
  assign wr_last  = phase_last(32'(ph_q), WR_CYC);
  assign gap_last = phase_last(32'(ph_q), GAP_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          ph_q <= '0;
          if (start_i) st_q <= ST_READ;
        end
        ST_READ: begin
          if (rd_last) begin st_q <= ST_WRITE; ph_q <= '0; end
          else ph_q <= ph_q + 1'b1;
        end
        ST_WRITE: begin
          if (wr_last) begin st_q <= ST_GAP; ph_q <= '0; end
          else ph_q <= ph_q + 1'b1;
        end
        ST_GAP: begin
          if (gap_last) begin st_q <= ST_IDLE; ph_q <= '0; end
          else ph_q <= ph_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = st_q;
  assign idle_o    = (st_q == ST_IDLE);
  assign rd_stb_o  = (st_q == ST_READ);
  assign wr_stb_o  = (st_q == ST_WRITE);
  assign capture_o = rd_stb_o && rd_last;
  assign wr_end_o  = wr_stb_o && wr_last;

endmodule

// File: rtl/lds_dma_seq.sv
module lds_dma_seq
  import lds_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int RD_CYC  = 2,
  parameter int WR_CYC  = 2,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_enable,
  input  logic              ctl_pin_mode,
  input  logic [CNT_W-1:0]  ctl_count,
  input  logic              req_n,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic              rd_stb,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  remaining,
  output logic              chan_on,
  output logic              done
);

  // Named internal events, also observed by the bound checker.
  lds_state_e state_w;
  logic idle_w, capture_w, wr_end_w, last_w;
  logic accept_w, pending_w;
  logic cfg_take_w, arm_w, start_w, open_w, close_w;
  logic [DATA_W-1:0] hold_q;

  assign cfg_take_w = ctl_wr && idle_w;
  assign arm_w      = cfg_take_w && ctl_enable && ctl_pin_mode && (ctl_count != '0);
  assign start_w    = idle_w && pending_w && chan_on && bus_gnt && !ctl_wr;
  assign open_w     = arm_w || (wr_end_w && !last_w);
  assign close_w    = start_w || cfg_take_w;

  lds_fsm #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .GAP_CYC(GAP_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_w),
    .state_o  (state_w),
    .idle_o   (idle_w),
    .rd_stb_o (rd_stb),
    .wr_stb_o (wr_stb),
    .capture_o(capture_w),
    .wr_end_o (wr_end_w)
  );

  lds_accept u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_i   (open_w),
    .close_i  (close_w),
    .pin_n_i  (req_n),
    .accept_o (accept_w),
    .pending_o(pending_w)
  );

  lds_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (cfg_take_w),
    .load_val_i(ctl_count),
    .dec_i     (wr_end_w),
    .count_o   (remaining),
    .last_o    (last_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_on <= 1'b0;
      done    <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (cfg_take_w)             chan_on <= arm_w;
      else if (wr_end_w && last_w) chan_on <= 1'b0;
      done <= wr_end_w && last_w;
      if (capture_w) hold_q <= rd_data;
    end
  end

  assign bus_req = (idle_w && pending_w) || rd_stb || wr_stb;
  assign wr_data = hold_q;

endmodule

// File: rtl/lds_checks.sv
module lds_checks #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic              bus_gnt,
  input logic              bus_req,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  remaining,
  input logic              chan_on,
  input logic              done,
  input logic              start_w,
  input logic              wr_end_w
);

  p_wait_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !rd_stb && !wr_stb && !bus_gnt && !ctl_wr) |=> bus_req);

  p_start_on_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |-> (bus_req && bus_gnt));

  p_start_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> rd_stb);

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_stb) |-> wr_stb);

  p_req_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> bus_req);

  p_data_moved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |-> (wr_data == $past(rd_data)));

  p_count_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end_w |=> (remaining == CNT_W'($past(remaining) - CNT_W'(1))));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!chan_on && remaining == '0));

  p_gap_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end_w |=> !bus_req);

  p_gap_second_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_end_w, 2) |-> !bus_req);

endmodule

bind lds_dma_seq lds_checks #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_wr   (ctl_wr),
  .bus_gnt  (bus_gnt),
  .bus_req  (bus_req),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .rd_data  (rd_data),
  .wr_data  (wr_data),
  .remaining(remaining),
  .chan_on  (chan_on),
  .done     (done),
  .start_w  (start_w),
  .wr_end_w (wr_end_w)
);

// File: tb/tb_lds_dma_seq.sv
`timescale 1ns/1ps
module tb_lds_dma_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0, ctl_enable = 1'b0, ctl_pin_mode = 1'b0;
  logic [15:0] ctl_count = '0;
  logic        req_n = 1'b1, bus_gnt = 1'b0;
  logic [31:0] rd_data = '0;
  logic        bus_req, rd_stb, wr_stb, chan_on, done;
  logic [31:0] wr_data;
  logic [15:0] remaining;

  int n_chk = 0, n_fail = 0;
  int xfers = 0, dones = 0, low_run = 0, last_gap = -1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lds_dma_seq dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_enable(ctl_enable),
    .ctl_pin_mode(ctl_pin_mode), .ctl_count(ctl_count), .req_n(req_n),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .rd_stb(rd_stb), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_data(wr_data), .remaining(remaining),
    .chan_on(chan_on), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase name, clocks spent in it, transfer log.
  int          m_phase, m_clk;     // 0 idle, 1 read, 2 write, 3 gap
  bit          m_open, m_held, m_on, m_done;
  int          m_left;
  logic [31:0] m_log[$];

  always @(posedge clk) begin
    bit idle, take, arm, go, wend;
    if (!rst_n) begin
      m_phase = 0; m_clk = 0; m_open = 0; m_held = 0; m_on = 0; m_done = 0; m_left = 0;
      m_log.delete();
    end else begin
      idle = (m_phase == 0);
      take = ctl_wr && idle;
      arm  = take && ctl_enable && ctl_pin_mode && (ctl_count != 0);
      go   = idle && m_held && m_on && bus_gnt && !ctl_wr;
      wend = (m_phase == 2) && (m_clk == 1);
      m_done = wend && (m_left == 1);
      if (m_held == 0 && m_open && !req_n && !go && !take) m_held = 1;
      if (go || take) m_held = 0;
      if (go) m_open = 0;
      if (take) begin m_open = arm; m_on = arm; m_left = ctl_count; end
      if (m_phase == 1 && m_clk == 1) m_log.push_back(rd_data);
      if (wend) begin
        void'(m_log.pop_front());
        m_left = m_left - 1;
        if (m_left == 0) m_on = 0; else m_open = 1;
      end
      if (m_phase == 0) begin
        m_clk = 0;
        if (go) m_phase = 1;
      end else if (m_clk == 1) begin
        m_clk = 0; m_phase = (m_phase + 1) % 4;
      end else m_clk++;
    end
  end

  // Cycle-by-cycle comparison on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 bus_req", bus_req, ((m_phase == 0 && m_held) || m_phase == 1 || m_phase == 2));
      chk("R5 rd_stb", rd_stb, m_phase == 1);
      chk("R5 wr_stb", wr_stb, m_phase == 2);
      if (m_phase == 2) chk("R6 wr_data", wr_data, m_log[0]);
      chk("R7 remaining", remaining, m_left);
      chk("R1 chan_on", chan_on, m_on);
      chk("R8 done", done, m_done);
      if (rd_stb && m_clk == 0) xfers++;
      if (done) dones++;
      if (bus_req) begin
        if (low_run > 0) last_gap = low_run;
        low_run = 0;
      end else low_run++;
    end
  end

  always @(posedge clk) rd_data <= rd_data * 32'd1103515245 + 32'd12345;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input bit en, input bit pm, input int cnt);
    ctl_wr = 1; ctl_enable = en; ctl_pin_mode = pm; ctl_count = 16'(cnt);
    tick(1);
    ctl_wr = 0;
  endtask

  initial begin
    int base;
    tick(3);
    // R10: reset values
    chk("R10 bus_req", bus_req, 0); chk("R10 rd_stb", rd_stb, 0);
    chk("R10 wr_stb", wr_stb, 0);   chk("R10 done", done, 0);
    chk("R10 chan_on", chan_on, 0); chk("R10 remaining", remaining, 0);
    rst_n = 1; tick(2);

    // R1: pin mode 0 and count 0 never start
    req_n = 0; bus_gnt = 1;
    cfg(1, 0, 4); tick(10);
    chk("R1 no xfer pin-mode 0", xfers, 0); chk("R1 chan_on off", chan_on, 0);
    cfg(1, 1, 0); tick(10);
    chk("R1 no xfer count 0", xfers, 0); chk("R1 bus_req idle", bus_req, 0);

    // R2/R3: first sample one edge after the write, request held without grant
    bus_gnt = 0; req_n = 0;
    cfg(1, 1, 5);
    chk("R1 chan_on set", chan_on, 1);
    chk("R2 not yet sampled", bus_req, 0);
    tick(1);
    chk("R2 sampled", bus_req, 1);
    req_n = 1; tick(3);
    chk("R3 held while waiting", bus_req, 1);
    // R4: grant starts, pin pulse during clear period ignored
    bus_gnt = 1; tick(1);
    chk("R4 read started", rd_stb, 1);
    req_n = 0; tick(2); req_n = 1;
    tick(15);
    chk("R4 single transfer", xfers, 1);
    chk("R7 one consumed", remaining, 4);

    // R11: a write during a transfer is ignored
    req_n = 0; tick(1); req_n = 1;
    while (!rd_stb) tick(1);
    cfg(0, 1, 99);
    tick(12);
    chk("R11 count kept", remaining, 3);
    chk("R11 channel kept", chan_on, 1);

    // R9/R8: pin held low runs out the count with a two-cycle gap
    base = xfers; req_n = 0;
    tick(60);
    chk("R9 gap length", last_gap, 2);
    chk("R8 remaining three run", xfers - base, 3);
    chk("R8 done once", dones, 1);
    chk("R8 channel off", chan_on, 0);
    chk("R8 remaining zero", remaining, 0);
    tick(20);
    chk("R8 no more transfers", xfers - base, 3);

    // R2 again with delayed pin and immediate grant
    req_n = 1; cfg(1, 1, 2); tick(4);
    chk("R2 high pin idle", bus_req, 0);
    req_n = 0; tick(40);
    chk("R8 second run done", dones, 2);
    chk("R7 second run count", remaining, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule